// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Done Queuing

The block gathers interrupt conditions from processing channels (done and error events), execution units and internal controller events into one status word, and drives a single level-sensitive interrupt line to a host. Each condition reaches its status bit only when the matching mask bit is set. The host finds the source by reading the status word, and acknowledges by writing ones to a clear word.

A condition that is still present when its bit is acknowledged makes the bit drop for exactly one cycle and then set again, while the interrupt line stays high throughout. Each channel done source carries a saturating pending counter. Completions that arrive while the done bit is already set are counted. Each acknowledge then re-raises the bit, after the same one-cycle gap, until the count is used up. No completion is lost, including one that arrives in the same cycle as the acknowledge.

The register port is a simple synchronous write strobe with a combinational read. Register words sit on 4-byte boundaries.

Top module: `irq_aggregator`

## Requirements
- R1: A status bit can be set by its source only in a cycle where its mask bit is 1; with the mask bit at 0 the source pulse leaves the status word unchanged.
- R2: `irq_o` is 1 whenever any status bit is 1, and it is 0 once every status bit is 0 and no re-raise is pending.
- R3: A write of 1 to a bit at the clear word (byte address 0x8) makes that status bit read 0 in the next cycle; bits written 0 are unchanged.
- R4: If the masked source of a bit is active in the cycle its clear is written, the bit reads 0 for exactly one cycle and then reads 1.
- R5: During that one-cycle gap `irq_o` stays 1.
- R6: Done events of a channel that arrive while its done bit is set (including every extra cycle a done input is held high) are counted, saturating at 15. Each clear of the bit then re-raises it after a one-cycle gap, until the count reaches 0.
- R7: A source event in the same cycle as a clear of its bit is never lost: the bit is re-raised after the gap, or queued for done bits.
- R8: Byte address 0x0 is the mask word (read/write, bits 27:0), 0x4 the status word (read-only), 0x8 the clear word (reads 0). Any address with bits 1:0 not 00 is ignored on write and reads 0, and address 0xC reads 0.
- R9: Status and mask bit layout: bits 7:0 are channel done 7..0, bits 15:8 channel error 7..0, bits 23:16 unit 7..0, bits 27:24 controller 3..0, and bits 31:28 always read 0.
- R10: Reset clears the mask, the status word and all pending counters, and drives `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_done_i | input | 8 | Channel done events, one cycle per event |
| chan_err_i | input | 8 | Channel error conditions, pulse or level |
| unit_evt_i | input | 8 | Execution unit conditions, pulse or level |
| ctrl_evt_i | input | 4 | Controller conditions, pulse or level |
| reg_addr_i | input | 4 | Register byte address |
| reg_wr_i | input | 1 | Write strobe for the current address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench holds an error level across its clear, to show the one-cycle zero in the status word with the line still high. A design that let the clear win for good would lose the interrupt, and one that drove the line from the status bits alone would show a one-cycle low pulse. Done bursts longer than the counter range are then drained one clear at a time. A counter that wrapped would deliver far too few re-raises, and one that missed a same-cycle event and clear would deliver one fewer. Unaligned writes to the mask are checked for no effect, and a long random phase mixes mask changes, clears and events so that any drift from the reference shows within a cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W = 32;
  // word index = byte address >> 2
  localparam int unsigned WORD_MASK = 0;
  localparam int unsigned WORD_STAT = 1;
  localparam int unsigned WORD_CLR  = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT,
    SEL_CLR
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC  = 28,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  reg_sel_e          sel;
  logic [N_SRC-1:0]  mask_q;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i[ADDR_W-1:2] == WORD_W'(WORD_MASK))      sel = SEL_MASK;
      else if (addr_i[ADDR_W-1:2] == WORD_W'(WORD_STAT)) sel = SEL_STAT;
      else if (addr_i[ADDR_W-1:2] == WORD_W'(WORD_CLR))  sel = SEL_CLR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mask_q <= '0;
    else if (wr_i && sel == SEL_MASK) mask_q <= wdata_i[N_SRC-1:0];
  end

  assign mask_o = mask_q;
  assign clr_o  = (wr_i && sel == SEL_CLR) ? wdata_i[N_SRC-1:0] : '0;

  always_comb begin
    unique case (sel)
      SEL_MASK: rdata_o = DATA_W'(mask_q);
      SEL_STAT: rdata_o = DATA_W'(status_i);
      default:  rdata_o = '0;
    endcase
  end

  if (N_SRC < DATA_W) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^wdata_i[DATA_W-1:N_SRC];
  end
endmodule

// File: rtl/irq_agg_qcell.sv
// Status bit with a saturating count of deliveries still owed.
module irq_agg_qcell #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic             clr_i,
  output logic             stat_o,
  output logic             rearm_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             stat_q, stat_n;
  logic             rearm_q, rearm_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             clr_eff;

  assign clr_eff = clr_i & stat_q;
  assign cnt_inc = (ev_i && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;

  always_comb begin
    stat_n  = stat_q;
    rearm_n = 1'b0;
    cnt_n   = cnt_q;
    if (rearm_q) begin
      stat_n = 1'b1;
      cnt_n  = cnt_inc;
    end else if (clr_eff) begin
      stat_n  = 1'b0;
      rearm_n = ev_i || (cnt_q != '0);
      // one owed delivery is consumed by the re-raise
      if (!ev_i && cnt_q != '0) cnt_n = cnt_q - CNT_W'(1);
    end else if (stat_q) begin
      cnt_n = cnt_inc;
    end else begin
      stat_n = ev_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= 1'b0;
      rearm_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      stat_q  <= stat_n;
      rearm_q <= rearm_n;
      cnt_q   <= cnt_n;
    end
  end

  assign stat_o  = stat_q;
  assign rearm_o = rearm_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/irq_agg_fcell.sv
// Status bit without queue; an event on a clear re-raises after one cycle.
module irq_agg_fcell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic clr_i,
  output logic stat_o,
  output logic rearm_o
);
  logic stat_q, rearm_q, clr_eff;

  assign clr_eff = clr_i & stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      stat_q  <= clr_eff ? 1'b0 : (stat_q | ev_i | rearm_q);
      rearm_q <= clr_eff & ev_i;
    end
  end

  assign stat_o  = stat_q;
  assign rearm_o = rearm_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_CHAN = 8,
  parameter int unsigned N_UNIT = 8,
  parameter int unsigned N_CTRL = 4,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CHAN-1:0] chan_done_i,
  input  logic [N_CHAN-1:0] chan_err_i,
  input  logic [N_UNIT-1:0] unit_evt_i,
  input  logic [N_CTRL-1:0] ctrl_evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned N_SRC = 2 * N_CHAN + N_UNIT + N_CTRL;

  logic [N_SRC-1:0]             raw_src, ev_vec, mask_q, clr_hit;
  logic [N_SRC-1:0]             status_q, rearm_q;
  logic [N_CHAN-1:0][CNT_W-1:0] cnt_q;

  assign raw_src = {ctrl_evt_i, unit_evt_i, chan_err_i, chan_done_i};
  assign ev_vec  = raw_src & mask_q;

  irq_agg_regif #(
    .N_SRC (N_SRC),
    .ADDR_W(ADDR_W)
  ) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .status_i(status_q),
    .mask_o  (mask_q),
    .clr_o   (clr_hit),
    .rdata_o (reg_rdata_o)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (i < N_CHAN) begin : g_queued
      irq_agg_qcell #(.CNT_W(CNT_W)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (ev_vec[i]),
        .clr_i  (clr_hit[i]),
        .stat_o (status_q[i]),
        .rearm_o(rearm_q[i]),
        .cnt_o  (cnt_q[i])
      );
    end else begin : g_plain
      irq_agg_fcell u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (ev_vec[i]),
        .clr_i  (clr_hit[i]),
        .stat_o (status_q[i]),
        .rearm_o(rearm_q[i])
      );
    end
  end

  // pending re-raise keeps the line up through the gap
  assign irq_o = |{status_q, rearm_q};
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC  = 28,
  parameter int unsigned N_CHAN = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_SRC-1:0]          raw_src,
  input logic [N_SRC-1:0]          mask_q,
  input logic [N_SRC-1:0]          clr_hit,
  input logic [N_SRC-1:0]          status_q,
  input logic [N_SRC-1:0]          rearm_q,
  input logic [N_CHAN-1:0][CNT_W-1:0] cnt_q,
  input logic [ADDR_W-1:0]         reg_addr_i,
  input logic                      reg_wr_i,
  input logic [DATA_W-1:0]         reg_rdata_o,
  input logic                      irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_mask_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~$past(status_q) & ~$past(rearm_q) & ~$past(raw_src & mask_q)) == '0)
    else $error("status bit set without masked source");

  p_irq_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_q) |-> irq_o) else $error("status set but line low");

  p_irq_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|{status_q, rearm_q})) else $error("line high with nothing pending");

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_hit & status_q)) |=> ((status_q & $past(clr_hit & status_q)) == '0))
    else $error("cleared bit still set");

  p_reraise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rearm_q) |=> ((status_q & $past(rearm_q)) == $past(rearm_q)))
    else $error("re-raise missing after gap");

  p_gap_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_hit & status_q & raw_src & mask_q)) |=> irq_o)
    else $error("line dropped in clear gap");

  for (genvar c = 0; c < N_CHAN; c++) begin : g_cnt
    p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[c] == CNT_MAX && !(clr_hit[c] && status_q[c])) |=> cnt_q[c] == CNT_MAX)
      else $error("done counter wrapped");
  end

  p_bad_addr_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[1:0] != 2'b00) |-> reg_rdata_o == '0)
    else $error("unaligned read returned data");

  p_bad_addr_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i[1:0] != 2'b00) |=> $stable(mask_q))
    else $error("unaligned write changed mask");
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N_SRC (N_SRC),
  .N_CHAN(N_CHAN),
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .raw_src    (raw_src),
  .mask_q     (mask_q),
  .clr_hit    (clr_hit),
  .status_q   (status_q),
  .rearm_q    (rearm_q),
  .cnt_q      (cnt_q),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  done = '0, err = '0, unit = '0;
  logic [3:0]  ctrl = '0;
  logic [3:0]  addr = 4'h4;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R10";

  // reference state
  int st[28];
  int rr[28];
  int q[28];
  logic [27:0] m_mask;

  always #2.5 clk = ~clk;

  irq_aggregator dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .chan_done_i(done), .chan_err_i(err), .unit_evt_i(unit), .ctrl_evt_i(ctrl),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] v;
    v = '0;
    if (a[1:0] != 2'b00) return '0;
    case (a[3:2])
      2'd0: v = {4'b0, m_mask};
      2'd1: for (int i = 0; i < 28; i++) v[i] = (st[i] != 0);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic m_irq();
    for (int i = 0; i < 28; i++) if (st[i] != 0 || rr[i] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 28; i++) begin st[i] = 0; rr[i] = 0; q[i] = 0; end
    m_mask = '0;
  endtask

  task automatic model_step();
    logic [27:0] src, clr;
    int cap, ev;
    src = {ctrl, unit, err, done};
    clr = (wr && addr == 4'h8) ? wdata[27:0] : '0;
    for (int i = 0; i < 28; i++) begin
      cap = (i < 8) ? 15 : 0;
      ev  = (src[i] && m_mask[i]) ? 1 : 0;
      if (rr[i] != 0) begin
        st[i] = 1; rr[i] = 0; q[i] = (q[i] + ev > cap) ? cap : q[i] + ev;
      end else if (clr[i] && st[i] != 0) begin
        st[i] = 0;
        if (q[i] + ev > 0) begin rr[i] = 1; q[i] = q[i] + ev - 1; end
      end else if (st[i] != 0) begin
        q[i] = (q[i] + ev > cap) ? cap : q[i] + ev;
      end else if (ev != 0) begin
        st[i] = 1;
      end
    end
    if (wr && addr == 4'h0) m_mask = wdata[27:0];
  endtask

  task automatic cyc(input logic [7:0] d, input logic [7:0] e, input logic [7:0] u,
                     input logic [3:0] c, input logic [3:0] a, input logic w,
                     input logic [31:0] wd);
    done = d; err = e; unit = u; ctrl = c; addr = a; wr = w; wdata = wd;
    #1;
    vectors++;
    if (rdata !== m_read(a)) begin
      miscompares++;
      $display("FAIL %s: rdata@%h = %h, expected %h", cur_req, a, rdata, m_read(a));
    end
    vectors++;
    if (irq !== m_irq()) begin
      miscompares++;
      $display("FAIL %s: irq_o = %b, expected %b", cur_req, irq, m_irq());
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc('0, '0, '0, '0, 4'h4, 1'b0, '0);
  endtask

  task automatic clear(input logic [31:0] v);
    cyc('0, '0, '0, '0, 4'h8, 1'b1, v);
  endtask

  task automatic set_mask(input logic [31:0] v);
    cyc('0, '0, '0, '0, 4'h0, 1'b1, v);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10: reset state
    cur_req = "R10";
    idle(2);
    cyc('0, '0, '0, '0, 4'h0, 1'b0, '0);

    // R8: address map and alignment
    cur_req = "R8";
    set_mask(32'hFFFF_FFFF);
    cyc('0, '0, '0, '0, 4'h0, 1'b0, '0);
    cyc('0, '0, '0, '0, 4'h1, 1'b1, '0);       // unaligned write ignored
    cyc('0, '0, '0, '0, 4'h2, 1'b1, '0);
    cyc('0, '0, '0, '0, 4'h0, 1'b0, '0);
    cyc('0, '0, '0, '0, 4'hC, 1'b0, '0);
    cyc('0, '0, '0, '0, 4'h8, 1'b0, '0);
    cyc('0, '0, '0, '0, 4'h5, 1'b0, '0);

    // R9: field layout
    cur_req = "R9";
    cyc('0, '0, 8'h08, '0, 4'h4, 1'b0, '0);
    cyc('0, '0, '0, 4'h2, 4'h4, 1'b0, '0);
    cyc('0, 8'h01, '0, '0, 4'h4, 1'b0, '0);
    cyc(8'h80, '0, '0, '0, 4'h4, 1'b0, '0);
    idle(2);
    clear(32'h0FFF_FFFF);
    idle(2);

    // R1: masked sources ignored
    cur_req = "R1";
    set_mask(32'h00FF_FFFF);
    cyc('0, '0, '0, 4'hF, 4'h4, 1'b0, '0);
    idle(2);
    set_mask(32'h0FFF_FF00);
    cyc(8'hFF, '0, '0, '0, 4'h4, 1'b0, '0);
    idle(2);
    set_mask(32'h0FFF_FFFF);

    // R3: write-1-to-clear, zeros ignored
    cur_req = "R3";
    cyc('0, '0, 8'h01, '0, 4'h4, 1'b0, '0);
    idle(1);
    clear(32'h0000_0000);
    idle(1);
    clear(32'h0000_0001);
    idle(1);
    clear(32'h0001_0000);
    idle(2);

    // R4/R5: level held across its clear
    cur_req = "R4";
    cyc('0, 8'h04, '0, '0, 4'h4, 1'b0, '0);
    cyc('0, 8'h04, '0, '0, 4'h4, 1'b0, '0);
    cur_req = "R5";
    cyc('0, 8'h04, '0, '0, 4'h8, 1'b1, 32'h0000_0400);
    cyc('0, 8'h04, '0, '0, 4'h4, 1'b0, '0);   // gap cycle
    cyc('0, 8'h04, '0, '0, 4'h4, 1'b0, '0);
    cur_req = "R4";
    cyc('0, '0, '0, '0, 4'h4, 1'b0, '0);
    clear(32'h0000_0400);
    idle(2);

    // R7: event coinciding with clear
    cur_req = "R7";
    cyc('0, 8'h20, '0, '0, 4'h4, 1'b0, '0);
    idle(1);
    cyc('0, 8'h20, '0, '0, 4'h8, 1'b1, 32'h0000_2000);
    idle(2);
    clear(32'h0000_2000);
    idle(1);
    cyc(8'h08, '0, '0, '0, 4'h4, 1'b0, '0);
    idle(1);
    cyc(8'h08, '0, '0, '0, 4'h8, 1'b1, 32'h0000_0008);
    idle(2);
    clear(32'h0000_0008);
    idle(2);

    // R6: done queue, then saturation
    cur_req = "R6";
    for (int k = 0; k < 5; k++) begin
      cyc(8'h02, '0, '0, '0, 4'h4, 1'b0, '0);
      idle(1);
    end
    for (int k = 0; k < 7; k++) begin
      clear(32'h0000_0002);
      idle(2);
    end
    for (int k = 0; k < 20; k++) cyc(8'h01, '0, '0, '0, 4'h4, 1'b0, '0);
    idle(1);
    for (int k = 0; k < 18; k++) begin
      clear(32'h0000_0001);
      idle(2);
    end

    // random mix
    cur_req = "R2";
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)
        cyc('0, '0, '0, '0, 4'h0, 1'b1, $urandom | 32'h0000_00FF);
      else if (r[5:4] == 2'd0)
        cyc($urandom & $urandom, $urandom & $urandom, $urandom & $urandom,
            4'($urandom), 4'h8, 1'b1, $urandom);
      else
        cyc(8'($urandom & $urandom & $urandom), 8'($urandom & $urandom),
            8'($urandom & $urandom), 4'($urandom & $urandom),
            4'($urandom), 1'b0, '0);
    end

    // R2: drain everything, line must fall
    set_mask(32'h0);
    for (int k = 0; k < 40; k++) begin
      clear(32'h0FFF_FFFF);
      idle(1);
    end
    idle(3);
    summary();
  end
endmodule